// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

This block lets two processor domains exchange short messages through a small register file. It holds a parameterised number of channels. Each channel has a control word carrying a message identifier, a fixed set of 32-bit payload words and a two-flag status register. A sender fills the payload words and then writes the control word with the request flag set. The hardware then marks the channel busy and raises the channel's interrupt flag. The receiver reads the identifier and payload, then writes the status register to release the channel.

All channels feed one global status word, with two bits per channel, and one global mask register. Together they drive a single interrupt line toward the receiving domain. Access goes through a plain register port: a one-cycle write strobe, and a read strobe whose data comes back one clock later with a valid flag.

Top module: `mbox_hub`

## Requirements
- R1: After reset every channel status register reads 0, the global status reads 0, the mask register reads 0x00FF0000 (every channel masked) and `irq_o` is 0.
- R2: Channel c occupies byte offsets 32*c to 32*c+31. The payload words sit at offsets +4, +8, +12 and +16 and read back the last value written to them.
- R3: A write to the control word (offset +0) with bit 31 set, made while the channel is not busy, stores bit 31 and the identifier in bits [30:0]. It also sets both the busy flag (status bit 0) and the interrupt flag (status bit 1). The status word is at offset +20.
- R4: A control write with bit 31 clear, made while the channel is not busy, stores the identifier and leaves both status flags unchanged.
- R5: While a channel is busy, writes to its control word and to its payload words are ignored, so a pending message cannot be overwritten.
- R6: A nonzero write to a channel status register clears exactly the flags whose bit positions (bit 0 busy, bit 1 interrupt) are written as one.
- R7: A write of zero to a channel status register clears both of its flags.
- R8: The global status register at offset 0x100 shows channel c's busy flag at bit 2c and its interrupt flag at bit 2c+1. All other bits read 0.
- R9: The mask register at offset 0x104 keeps one bit per channel at bit 16+c. A one masks the channel. Other bit positions are not stored and read 0.
- R10: `irq_o` is the OR over channels of (interrupt flag AND NOT mask bit). It changes one clock after the register write that changes that value.
- R11: Reads return data one clock after the read strobe, with `bus_rvalid` high for that cycle. Unmapped offsets (channel words +24 and +28, and global offsets other than 0x100 and 0x104) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 9 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after bus_re |
| irq_o | output | 1 | Combined unmasked channel interrupt |

## Verification
The assertions assume that a write and a read never occur in the same cycle. They also assume that addresses are word aligned and that a control write and a status write never target one channel in the same cycle. The single register port guarantees the last of these. The stimulus drives one strobe per cycle through separate write and read tasks and uses only aligned offsets. The collision and zero-clear properties therefore see only the orderings a real sender and receiver would produce.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int unsigned WORD_BITS   = 32;
   localparam int unsigned CH_STRIDE_B = 32;
   localparam int unsigned WORD_CTRL   = 0;
   localparam int unsigned WORD_DATA0  = 1;
   localparam int unsigned STS_BUSY    = 0;
   localparam int unsigned STS_IRQ     = 1;
   localparam int unsigned REQ_BIT     = 31;
   localparam int unsigned GOFF_STAT   = 0;
   localparam int unsigned GOFF_MASK   = 4;
   typedef logic [WORD_BITS-1:0] word_t;
endpackage

// File: rtl/mbox_chan.sv
module mbox_chan
   import mbox_pkg::*;
#(
   parameter int unsigned DATA_WORDS = 4,
   parameter int unsigned ID_W       = 31
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctrl_we,
   input  logic [DATA_WORDS-1:0] data_we,
   input  logic                  sts_we,
   input  word_t                 wdata,
   input  logic [2:0]            rd_word,
   output word_t                 rd_data,
   output logic                  busy_o,
   output logic                  irq_o
);
   localparam int unsigned DIW       = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
   localparam int unsigned WORD_STS  = WORD_DATA0 + DATA_WORDS;
   localparam word_t       CTRL_KEEP = {1'b1, 31'((64'd1 << ID_W) - 64'd1)};

   word_t ctrl_q;
   word_t data_q [DATA_WORDS];
   logic  busy_q, irq_q;
   logic  accept;

   assign accept = !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         busy_q <= 1'b0;
         irq_q  <= 1'b0;
      end else if (ctrl_we && accept) begin
         ctrl_q <= wdata & CTRL_KEEP;
         if (wdata[REQ_BIT]) begin
            busy_q <= 1'b1;
            irq_q  <= 1'b1;
         end
      end else if (sts_we) begin
         if (wdata == '0) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b0;
         end else begin
            busy_q <= busy_q & ~wdata[STS_BUSY];
            irq_q  <= irq_q  & ~wdata[STS_IRQ];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DATA_WORDS; k++) data_q[k] <= '0;
      end else begin
         for (int k = 0; k < DATA_WORDS; k++)
            if (data_we[k] && accept) data_q[k] <= wdata;
      end
   end

   logic [2:0] didx;
   assign didx = rd_word - 3'(WORD_DATA0);

   always_comb begin
      rd_data = '0;
      if (rd_word == 3'(WORD_CTRL))
         rd_data = ctrl_q;
      else if (rd_word == 3'(WORD_STS))
         rd_data = {30'd0, irq_q, busy_q};
      else if (rd_word >= 3'(WORD_DATA0) && rd_word < 3'(WORD_STS))
         rd_data = data_q[didx[DIW-1:0]];
   end

   assign busy_o = busy_q;
   assign irq_o  = irq_q;

   p_send_sets_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !busy_q && wdata[REQ_BIT]) |=> (busy_q && irq_q));
   p_plain_ctrl_keeps_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !wdata[REQ_BIT] && !sts_we) |=> ($stable(busy_q) && $stable(irq_q)));
   p_collision_holds_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && busy_q) |=> $stable(ctrl_q));
   p_zero_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && !ctrl_we && wdata == '0) |=> (!busy_q && !irq_q));
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
   parameter int unsigned N_CH = 8
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mask_we,
   input  logic [N_CH-1:0] mask_wdata,
   input  logic [N_CH-1:0] irq_vec,
   output logic [N_CH-1:0] mask_o,
   output logic            irq_o
);
   logic [N_CH-1:0] mask_q;
   logic            irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         irq_q  <= 1'b0;
      end else begin
         if (mask_we) mask_q <= mask_wdata;
         irq_q <= |(irq_vec & ~mask_q);
      end
   end

   assign mask_o = mask_q;
   assign irq_o  = irq_q;

   p_all_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |=> !irq_o);
   p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == $past(|(irq_vec & ~mask_o)));
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub
   import mbox_pkg::*;
#(
   parameter int unsigned N_CH       = 8,
   parameter int unsigned DATA_WORDS = 4,
   parameter int unsigned ID_W       = 31,
   parameter int unsigned MASK_START = 16,
   parameter int unsigned ADDR_W     = 9
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   output logic              irq_o
);
   localparam int unsigned CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1;
   localparam int unsigned GBASE    = N_CH * CH_STRIDE_B;
   localparam int unsigned WORD_STS = WORD_DATA0 + DATA_WORDS;
   localparam logic [ADDR_W-1:0] GSTAT_A = ADDR_W'(GBASE + GOFF_STAT);
   localparam logic [ADDR_W-1:0] GMASK_A = ADDR_W'(GBASE + GOFF_MASK);
   localparam logic [ADDR_W-1:0] GBASE_A = ADDR_W'(GBASE);

   if (N_CH < 2 || 2 * N_CH > 32) begin : g_bad_nch
      $error("N_CH must lie in 2..16");
   end
   if (MASK_START + N_CH > 32) begin : g_bad_mask
      $error("mask field exceeds word");
   end
   if (ID_W < 1 || ID_W > 31) begin : g_bad_id
      $error("ID_W must lie in 1..31");
   end
   if (DATA_WORDS < 1 || DATA_WORDS > 6) begin : g_bad_dw
      $error("DATA_WORDS must lie in 1..6");
   end
   if ((64'd1 << ADDR_W) < 64'(GBASE + 8)) begin : g_bad_aw
      $error("ADDR_W too small for map");
   end

   logic            in_ch;
   logic [CH_W-1:0] ch_sel;
   logic [2:0]      wsel;
   assign in_ch  = bus_addr < GBASE_A;
   assign ch_sel = bus_addr[5 +: CH_W];
   assign wsel   = bus_addr[4:2];

   logic [N_CH-1:0] busy_vec, irq_vec, mask_vec;
   word_t           ch_rd [N_CH];
   word_t           gstat;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic            hit;
      logic [DATA_WORDS-1:0] dwe;
      assign hit = bus_we && in_ch && (ch_sel == CH_W'(c));
      for (genvar k = 0; k < DATA_WORDS; k++) begin : g_dwe
         assign dwe[k] = hit && (wsel == 3'(WORD_DATA0 + k));
      end
      mbox_chan #(.DATA_WORDS(DATA_WORDS), .ID_W(ID_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctrl_we (hit && (wsel == 3'(WORD_CTRL))),
         .data_we (dwe),
         .sts_we  (hit && (wsel == 3'(WORD_STS))),
         .wdata   (bus_wdata),
         .rd_word (wsel),
         .rd_data (ch_rd[c]),
         .busy_o  (busy_vec[c]),
         .irq_o   (irq_vec[c])
      );
      assign gstat[2*c]   = busy_vec[c];
      assign gstat[2*c+1] = irq_vec[c];
   end
   if (2 * N_CH < 32) begin : g_gpad
      assign gstat[31:2*N_CH] = '0;
   end

   mbox_irq #(.N_CH(N_CH)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_we    (bus_we && (bus_addr == GMASK_A)),
      .mask_wdata (bus_wdata[MASK_START +: N_CH]),
      .irq_vec    (irq_vec),
      .mask_o     (mask_vec),
      .irq_o      (irq_o)
   );

   word_t rd_next;
   always_comb begin
      rd_next = '0;
      if (in_ch)                   rd_next = ch_rd[ch_sel];
      else if (bus_addr == GSTAT_A) rd_next = gstat;
      else if (bus_addr == GMASK_A) rd_next = 32'(mask_vec) << MASK_START;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= bus_re;
         if (bus_re) bus_rdata <= rd_next;
      end
   end

   p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re |=> bus_rvalid);
   p_gstat_pairs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gstat) == $countones(busy_vec) + $countones(irq_vec));
endmodule

// File: tb/tb_mbox_hub.sv
module tb_mbox_hub;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid, irq_o;

   always #2.5 clk = ~clk;

   mbox_hub dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .irq_o(irq_o)
   );

   int    checks = 0, errors = 0;
   bit    done = 1'b0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      bus_re = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      repeat (2) @(negedge clk);
      chk(tag, {31'd0, irq_o}, {31'd0, exp});
   endtask

   // monitor: pops one expectation per returned read
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) chk("R11 unexpected rvalid", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
      rd(9'h014, 32'h0, "R1 ch0 status");
      rd(9'h100, 32'h0, "R1 global status");
      rd(9'h104, 32'h00FF0000, "R1 R9 mask reset");
      rd(9'h018, 32'h0, "R11 unmapped channel word");
      rd(9'h108, 32'h0, "R11 unmapped global word");
      // R2 payload on channel 2
      for (int k = 0; k < 4; k++) wr(9'(9'h044 + 4*k), 32'h1111_0000 + 32'(k));
      for (int k = 0; k < 4; k++) rd(9'(9'h044 + 4*k), 32'h1111_0000 + 32'(k), "R2 payload");
      // R3 send
      wr(9'h040, 32'h8000_0055);
      rd(9'h040, 32'h8000_0055, "R3 ctrl id");
      rd(9'h054, 32'h3, "R3 status flags");
      rd(9'h100, 32'h30, "R8 gstat ch2");
      chk_irq(1'b0, "R9 masked channel quiet");
      // R5 collision
      wr(9'h040, 32'h8000_0077);
      wr(9'h044, 32'hDEAD_BEEF);
      rd(9'h040, 32'h8000_0055, "R5 ctrl kept");
      rd(9'h044, 32'h1111_0000, "R5 payload kept");
      // R9/R10 unmask ch2
      wr(9'h104, 32'hFFFB_FFFF);
      rd(9'h104, 32'h00FB0000, "R9 mask stored bits only");
      chk_irq(1'b1, "R10 unmasked irq");
      // R6 clear irq flag only
      wr(9'h054, 32'h2);
      rd(9'h054, 32'h1, "R6 irq cleared busy kept");
      rd(9'h100, 32'h10, "R8 gstat busy only");
      chk_irq(1'b0, "R10 irq drops");
      // R4 plain control on ch5
      wr(9'h0A0, 32'h0000_1234);
      rd(9'h0A0, 32'h0000_1234, "R4 ctrl stored");
      rd(9'h0B4, 32'h0, "R4 no flags");
      wr(9'h054, 32'h1);
      rd(9'h054, 32'h0, "R6 busy cleared");
      // R7 zero write clears
      wr(9'h0A0, 32'h8000_0001);
      rd(9'h0B4, 32'h3, "R3 ch5 flags");
      rd(9'h100, 32'hC00, "R8 gstat ch5");
      wr(9'h0B4, 32'h0);
      rd(9'h0B4, 32'h0, "R7 zero clears");
      // R10 ch7 with mask open then closed
      wr(9'h0E0, 32'h8000_0009);
      wr(9'h104, 32'h0);
      chk_irq(1'b1, "R10 ch7 irq");
      rd(9'h100, 32'hC000, "R8 gstat ch7");
      wr(9'h104, 32'hFFFF_FFFF);
      chk_irq(1'b0, "R9 all masked");
      rd(9'h104, 32'h00FF0000, "R9 mask all ones");
      repeat (4) @(negedge clk);
      chk("R11 all reads returned", 32'(exp_q.size()), 32'd0);
      finish_run();
   end
endmodule